// File: doc/BRIEF.md
# Serial Transmit Byte Queue with Threshold Flags

This block holds the bytes a serial transmitter still has to send. A processor or a DMA engine pushes bytes in one per clock. Each frame tick removes the oldest byte while the transmitter is switched on. The block tracks how many bytes are waiting and keeps three status outputs. The first is a "queue running low" flag, measured against a selectable threshold. The second is a "nothing left to send" flag. The third is a transmit interrupt request.

The queue has a default depth of 16. The low-water threshold is half the depth, shifted right by a 2-bit select code. DMA pushes clear the flags on their own. Processor pushes leave the flags alone, and software clears them with a status write. That write only takes effect when the underlying condition is really gone.

Each removed byte leaves on a one-cycle valid/data strobe toward the line side. When internal loopback is on, the byte goes to a receive-side strobe instead, and only when reception is enabled.

Top module: `sertx_fifo`

## Requirements
- R1: After reset the count is 0, the low flag (`dempty_flag`) is 1, the end flag (`tend_flag`) is 1, `tx_irq` is 0, and neither valid strobe is high.
- R2: A push (`wr_en`) on a non-full queue stores `wr_data` and raises the count by one. A processor push (`wr_from_dma`=0) changes neither flag.
- R3: A push while the count equals the depth (16) is dropped, with no error indication. This holds even when a byte is removed in the same cycle. The dropped byte is never emitted.
- R4: A byte is removed only in a cycle where `frame_tick`=1, `tx_enable`=1 and the count is above 0. Bytes leave in push order. The removed byte appears one cycle later as a single-cycle `tx_valid` pulse with `tx_data`.
- R5: When a removal leaves a count at or below the threshold, `dempty_flag` is set. The threshold for `trig_sel` is: 0→8, 1→4, 2→2, 3→1.
- R6: When a removal leaves the count at 0, `tend_flag` is set. Whenever the count is 0, `tend_flag` reads 1.
- R7: A removal that sets `dempty_flag` while `irq_enable`=1 raises `tx_irq`. With `irq_enable`=0 it does not.
- R8: A DMA push (`wr_from_dma`=1) clears `tend_flag`. If the new count is above the threshold, it also clears `dempty_flag` and the pending interrupt.
- R9: A status write (`stat_wr`) with a keep bit at 0 clears `tend_flag` only if the count is not 0. It clears `dempty_flag` (and the pending interrupt) only if the count is above the threshold. Otherwise the write has no effect.
- R10: A queue reset pulse (`fifo_rst`) empties the queue and sets both flags. If `irq_enable`=1 it also raises `tx_irq`. It takes priority over a push or removal in the same cycle.
- R11: With `loopback_en`=1, a removed byte goes to `lb_valid`/`lb_data` if `rx_enable`=1, and is discarded otherwise. It never appears on `tx_valid`. The two strobes are never high together.
- R12: Lowering `irq_enable` drops `tx_irq` in the same cycle. The pending request is discarded and does not return when the enable is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 8 | Byte to push |
| wr_from_dma | input | 1 | Push comes from the DMA engine |
| stat_wr | input | 1 | Status write strobe |
| stat_keep_dempty | input | 1 | Status write value for the low flag (0 requests clear) |
| stat_keep_tend | input | 1 | Status write value for the end flag (0 requests clear) |
| trig_sel | input | 2 | Threshold select code |
| tx_enable | input | 1 | Transmitter enable |
| frame_tick | input | 1 | One frame time elapsed |
| fifo_rst | input | 1 | Queue reset pulse |
| irq_enable | input | 1 | Transmit interrupt enable |
| loopback_en | input | 1 | Route removed bytes to the receive side |
| rx_enable | input | 1 | Receive side accepts looped bytes |
| tx_valid | output | 1 | Line-side byte strobe |
| tx_data | output | 8 | Line-side byte |
| lb_valid | output | 1 | Loopback byte strobe |
| lb_data | output | 8 | Loopback byte |
| tx_count | output | 5 | Bytes currently queued |
| dempty_flag | output | 1 | Count at or below threshold after a removal |
| tend_flag | output | 1 | Queue drained |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Count, both flags and both strobes are registered. Each reflects the inputs sampled at one rising edge and is visible just after that edge. The bench's reference model therefore updates on the same edge and is compared 2 ns later, before the next input change at the falling edge. `tx_irq` is the only output that also follows an input in the same cycle. Lowering `irq_enable` must remove it at once, so that case is checked 1 ns after the enable changes, without waiting for an edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    ROUTE_LINE = 2'd0,
    ROUTE_LOOP = 2'd1,
    ROUTE_DROP = 2'd2
  } route_e;

  // Low-water level: half the depth, halved again per select step.
  function automatic int unsigned trig_level(input int unsigned depth,
                                             input logic [1:0] code);
    return (depth / 2) >> code;
  endfunction

  function automatic route_e pick_route(input logic loop, input logic rx);
    if (!loop) return ROUTE_LINE;
    if (rx) return ROUTE_LOOP;
    return ROUTE_DROP;
  endfunction

endpackage

// File: rtl/sertx_store.sv
module sertx_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nx,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign rdata  = mem[rd_ptr];
  assign cnt_nx = clr ? '0 : cnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      cnt <= cnt_nx;
    end
  end

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_rst,
  input  logic          pop,
  input  logic          push,
  input  logic          dma,
  input  logic          stat_wr,
  input  logic          keep_dempty,
  input  logic          keep_tend,
  input  logic          irq_en,
  input  logic [CW-1:0] cnt_nx,
  input  logic [CW-1:0] trig,
  output logic          dempty,
  output logic          tend,
  output logic          irq_q,
  output logic          dempty_set,
  output logic          dempty_clr,
  output logic          tend_set,
  output logic          tend_clr
);

  logic above;

  assign above      = (cnt_nx > trig);
  assign dempty_set = pop && !above;
  assign dempty_clr = above && ((push && dma) || (stat_wr && !keep_dempty));
  assign tend_set   = pop && (cnt_nx == '0);
  assign tend_clr   = (push && dma) || (stat_wr && !keep_tend && (cnt_nx != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dempty <= 1'b1;
      tend   <= 1'b1;
      irq_q  <= 1'b0;
    end else if (fifo_rst) begin
      dempty <= 1'b1;
      tend   <= 1'b1;
      irq_q  <= irq_en;
    end else begin
      dempty <= dempty_set | (dempty & ~dempty_clr);
      tend   <= tend_set | (tend & ~tend_clr);
      irq_q  <= irq_en & (dempty_set | (irq_q & ~dempty_clr));
    end
  end

endmodule

// File: rtl/sertx_route.sv
module sertx_route #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [DW-1:0] pop_data,
  input  logic          loop_en,
  input  logic          rx_en,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          lb_valid,
  output logic [DW-1:0] lb_data
);
  import sertx_pkg::*;

  route_e dest;
  assign dest = pick_route(loop_en, rx_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      lb_valid <= 1'b0;
      tx_data  <= '0;
      lb_data  <= '0;
    end else begin
      tx_valid <= pop && (dest == ROUTE_LINE);
      lb_valid <= pop && (dest == ROUTE_LOOP);
      if (pop && dest == ROUTE_LINE) tx_data <= pop_data;
      if (pop && dest == ROUTE_LOOP) lb_data <= pop_data;
    end
  end

endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_from_dma,
  input  logic          stat_wr,
  input  logic          stat_keep_dempty,
  input  logic          stat_keep_tend,
  input  logic [1:0]    trig_sel,
  input  logic          tx_enable,
  input  logic          frame_tick,
  input  logic          fifo_rst,
  input  logic          irq_enable,
  input  logic          loopback_en,
  input  logic          rx_enable,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          lb_valid,
  output logic [DW-1:0] lb_data,
  output logic [CW-1:0] tx_count,
  output logic          dempty_flag,
  output logic          tend_flag,
  output logic          tx_irq
);

  logic          full, empty;
  logic          pop_ok, push_ok;
  logic [CW-1:0] cnt_nx, trig;
  logic [DW-1:0] head_byte;
  logic          irq_q;
  logic          ev_dempty_set, ev_dempty_clr, ev_tend_set, ev_tend_clr;

  assign trig    = CW'(sertx_pkg::trig_level(DEPTH, trig_sel));
  assign pop_ok  = !fifo_rst && frame_tick && tx_enable && !empty;
  assign push_ok = !fifo_rst && wr_en && !full;
  assign tx_irq  = irq_q & irq_enable;

  sertx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_rst),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (wr_data),
    .rdata (head_byte),
    .cnt   (tx_count),
    .cnt_nx(cnt_nx),
    .full  (full),
    .empty (empty)
  );

  sertx_flags #(.CW(CW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_rst   (fifo_rst),
    .pop        (pop_ok),
    .push       (push_ok),
    .dma        (wr_from_dma),
    .stat_wr    (stat_wr && !fifo_rst),
    .keep_dempty(stat_keep_dempty),
    .keep_tend  (stat_keep_tend),
    .irq_en     (irq_enable),
    .cnt_nx     (cnt_nx),
    .trig       (trig),
    .dempty     (dempty_flag),
    .tend       (tend_flag),
    .irq_q      (irq_q),
    .dempty_set (ev_dempty_set),
    .dempty_clr (ev_dempty_clr),
    .tend_set   (ev_tend_set),
    .tend_clr   (ev_tend_clr)
  );

  sertx_route #(.DW(DW)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop     (pop_ok),
    .pop_data(head_byte),
    .loop_en (loopback_en),
    .rx_en   (rx_enable),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .lb_valid(lb_valid),
    .lb_data (lb_data)
  );

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_from_dma,
  input logic          stat_wr,
  input logic          tx_enable,
  input logic          frame_tick,
  input logic          fifo_rst,
  input logic          irq_enable,
  input logic          loopback_en,
  input logic          tx_valid,
  input logic          lb_valid,
  input logic [CW-1:0] tx_count,
  input logic          dempty_flag,
  input logic          tend_flag,
  input logic          tx_irq,
  input logic          ev_dempty_set,
  input logic          ev_dempty_clr
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH) && wr_en && !fifo_rst && !(frame_tick && tx_enable))
      |=> tx_count == CW'(DEPTH));

  p_cpu_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_from_dma && !stat_wr && !frame_tick && !fifo_rst)
      |=> ($stable(dempty_flag) && $stable(tend_flag)));

  p_no_pop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (!tx_valid && !lb_valid));

  p_empty_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> tend_flag);

  p_set_clr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_dempty_set && ev_dempty_clr));

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |=> !tx_irq);

  p_qreset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> (tx_count == '0 && dempty_flag && tend_flag));

  p_route_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && lb_valid));

  p_loop_no_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_en |=> !tx_valid);

endmodule

bind sertx_fifo sertx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_from_dma  (wr_from_dma),
  .stat_wr      (stat_wr),
  .tx_enable    (tx_enable),
  .frame_tick   (frame_tick),
  .fifo_rst     (fifo_rst),
  .irq_enable   (irq_enable),
  .loopback_en  (loopback_en),
  .tx_valid     (tx_valid),
  .lb_valid     (lb_valid),
  .tx_count     (tx_count),
  .dempty_flag  (dempty_flag),
  .tend_flag    (tend_flag),
  .tx_irq       (tx_irq),
  .ev_dempty_set(ev_dempty_set),
  .ev_dempty_clr(ev_dempty_clr)
);

// File: tb/sim_sertx_fifo.sv
`timescale 1ns/1ps
module sim_sertx_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_from_dma = 0, stat_wr = 0;
  logic       stat_keep_dempty = 1, stat_keep_tend = 1;
  logic [7:0] wr_data = 0;
  logic [1:0] trig_sel = 0;
  logic       tx_enable = 0, frame_tick = 0, fifo_rst = 0;
  logic       irq_enable = 0, loopback_en = 0, rx_enable = 0;
  logic       tx_valid, lb_valid, dempty_flag, tend_flag, tx_irq;
  logic [7:0] tx_data, lb_data;
  logic [4:0] tx_count;

  always #5 clk = ~clk;

  sertx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_from_dma(wr_from_dma), .stat_wr(stat_wr),
    .stat_keep_dempty(stat_keep_dempty), .stat_keep_tend(stat_keep_tend),
    .trig_sel(trig_sel), .tx_enable(tx_enable), .frame_tick(frame_tick),
    .fifo_rst(fifo_rst), .irq_enable(irq_enable), .loopback_en(loopback_en),
    .rx_enable(rx_enable), .tx_valid(tx_valid), .tx_data(tx_data),
    .lb_valid(lb_valid), .lb_data(lb_data), .tx_count(tx_count),
    .dempty_flag(dempty_flag), .tend_flag(tend_flag), .tx_irq(tx_irq)
  );

  int nchk = 0, nfail = 0;
  int n_tx = 0, n_lb = 0;
  bit done = 0, reported = 0;

  task automatic check_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // Behavioural reference model
  logic [7:0] q[$];
  bit   m_dempty = 1, m_tend = 1, m_irq = 0, m_txv = 0, m_lbv = 0;
  logic [7:0] m_txd = 0, m_lbd = 0, b;
  int   trig, n;
  bit   pop, push, dclr;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_dempty = 1; m_tend = 1; m_irq = 0; m_txv = 0; m_lbv = 0;
    end else if (fifo_rst) begin
      q.delete(); m_dempty = 1; m_tend = 1; m_irq = irq_enable; m_txv = 0; m_lbv = 0;
    end else begin
      trig = 8 >> trig_sel;
      pop  = frame_tick && tx_enable && q.size() > 0;
      push = wr_en && q.size() < 16;
      m_txv = 0; m_lbv = 0;
      if (pop) begin
        b = q.pop_front();
        if (!loopback_en) begin m_txv = 1; m_txd = b; end
        else if (rx_enable) begin m_lbv = 1; m_lbd = b; end
      end
      if (push) q.push_back(wr_data);
      n = q.size();
      dclr = (n > trig) && ((push && wr_from_dma) || (stat_wr && !stat_keep_dempty));
      if (pop && n <= trig) begin m_dempty = 1; if (irq_enable) m_irq = 1; end
      if (dclr) begin m_dempty = 0; m_irq = 0; end
      if (pop && n == 0) m_tend = 1;
      if ((push && wr_from_dma) || (stat_wr && !stat_keep_tend && n != 0)) m_tend = 0;
      if (!irq_enable) m_irq = 0;
    end
  end

  // Per-cycle comparison, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (tx_valid) n_tx++;
    if (lb_valid) n_lb++;
    check_eq("R2 count", int'(tx_count), q.size());
    check_eq("R5 dempty", int'(dempty_flag), int'(m_dempty));
    check_eq("R6 tend", int'(tend_flag), int'(m_tend));
    check_eq("R7 irq", int'(tx_irq), int'(m_irq && irq_enable));
    check_eq("R4 tx_valid", int'(tx_valid), int'(m_txv));
    if (m_txv) check_eq("R4 tx_data", int'(tx_data), int'(m_txd));
    check_eq("R11 lb_valid", int'(lb_valid), int'(m_lbv));
    if (m_lbv) check_eq("R11 lb_data", int'(lb_data), int'(m_lbd));
  end

  task automatic push_byte(input logic [7:0] d, input logic dma);
    wr_en = 1; wr_data = d; wr_from_dma = dma;
    @(negedge clk);
    wr_en = 0; wr_from_dma = 0;
  endtask

  task automatic tick();
    frame_tick = 1;
    @(negedge clk);
    frame_tick = 0;
  endtask

  task automatic stat_clear();
    stat_wr = 1; stat_keep_dempty = 0; stat_keep_tend = 0;
    @(negedge clk);
    stat_wr = 0; stat_keep_dempty = 1; stat_keep_tend = 1;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 count", int'(tx_count), 0);
    check_eq("R1 dempty", int'(dempty_flag), 1);
    check_eq("R1 tend", int'(tend_flag), 1);
    check_eq("R1 irq", int'(tx_irq), 0);
    check_eq("R1 strobes", int'(tx_valid | lb_valid), 0);

    // R2: CPU pushes leave flags untouched; fill to full
    for (int i = 0; i < 16; i++) push_byte(8'(i * 3 + 1), 0);
    check_eq("R2 count full", int'(tx_count), 16);
    check_eq("R2 dempty kept", int'(dempty_flag), 1);
    check_eq("R2 tend kept", int'(tend_flag), 1);
    // R3: push to full queue dropped
    push_byte(8'hEE, 0);
    check_eq("R3 count stays", int'(tx_count), 16);

    // R9: status clear above threshold works
    stat_clear();
    check_eq("R9 dempty cleared", int'(dempty_flag), 0);
    check_eq("R9 tend cleared", int'(tend_flag), 0);

    // R5/R7 drain with threshold 8
    irq_enable = 1; tx_enable = 1;
    for (int i = 0; i < 7; i++) begin tick(); @(negedge clk); end
    check_eq("R5 above trig", int'(dempty_flag), 0);
    tick();
    check_eq("R5 at trig", int'(dempty_flag), 1);
    check_eq("R7 irq raised", int'(tx_irq), 1);
    for (int i = 0; i < 8; i++) begin tick(); @(negedge clk); end
    check_eq("R6 drained tend", int'(tend_flag), 1);
    check_eq("R3 emitted 16", n_tx, 16);

    // R12: enable low drops irq at once, no return
    irq_enable = 0; #1;
    check_eq("R12 irq dropped", int'(tx_irq), 0);
    @(negedge clk);
    irq_enable = 1; #1;
    check_eq("R12 irq not back", int'(tx_irq), 0);
    @(negedge clk);

    // R4: no removal while disabled
    tx_enable = 0;
    base = n_tx;
    push_byte(8'h55, 0);
    tick(); @(negedge clk);
    check_eq("R4 held count", int'(tx_count), 1);
    check_eq("R4 no strobe", n_tx, base);
    tx_enable = 1;
    tick();
    check_eq("R4 strobe", int'(tx_valid), 1);
    check_eq("R4 data", int'(tx_data), 8'h55);
    @(negedge clk);

    // R9: clears ignored on an empty queue at/below threshold
    stat_clear();
    check_eq("R9 tend kept empty", int'(tend_flag), 1);
    check_eq("R9 dempty kept", int'(dempty_flag), 1);

    // R8: DMA pushes, threshold 1
    trig_sel = 2'd3;
    push_byte(8'hA0, 1);
    check_eq("R8 tend cleared", int'(tend_flag), 0);
    check_eq("R8 dempty kept", int'(dempty_flag), 1);
    check_eq("R8 irq kept", int'(tx_irq), 1);
    push_byte(8'hA1, 1);
    check_eq("R8 dempty cleared", int'(dempty_flag), 0);
    check_eq("R8 irq cleared", int'(tx_irq), 0);

    // R10: queue reset
    fifo_rst = 1; @(negedge clk); fifo_rst = 0;
    check_eq("R10 count", int'(tx_count), 0);
    check_eq("R10 dempty", int'(dempty_flag), 1);
    check_eq("R10 tend", int'(tend_flag), 1);
    check_eq("R10 irq", int'(tx_irq), 1);

    // R11: loopback with and without reception
    loopback_en = 1; rx_enable = 1; trig_sel = 2'd1;
    base = n_tx;
    push_byte(8'h11, 0); push_byte(8'h22, 0); push_byte(8'h33, 0);
    for (int i = 0; i < 3; i++) begin tick(); @(negedge clk); end
    check_eq("R11 looped", n_lb, 3);
    check_eq("R11 none on line", n_tx, base);
    rx_enable = 0;
    push_byte(8'h44, 0);
    tick(); @(negedge clk);
    check_eq("R11 drop count", int'(tx_count), 0);
    check_eq("R11 drop strobes", n_lb + n_tx, 3 + base);
    loopback_en = 0;

    // Mixed push/removal, threshold 2
    trig_sel = 2'd2;
    for (int i = 0; i < 4; i++) push_byte(8'(8'h60 + i), 0);
    wr_en = 1; wr_data = 8'h70; frame_tick = 1; @(negedge clk);
    wr_from_dma = 1; wr_data = 8'h71; @(negedge clk);
    wr_en = 0; wr_from_dma = 0; frame_tick = 0;
    check_eq("R8 dma with pop", int'(tx_count), 4);

    // R3: full plus removal in same cycle drops the push
    for (int i = 0; i < 12; i++) push_byte(8'(8'h80 + i), 0);
    wr_en = 1; wr_data = 8'h77; frame_tick = 1; @(negedge clk);
    wr_en = 0; frame_tick = 0;
    check_eq("R3 full+pop", int'(tx_count), 15);
    for (int i = 0; i < 15; i++) begin tick(); @(negedge clk); end
    check_eq("R6 final drain", int'(tend_flag), 1);
    repeat (3) @(negedge clk);
    done = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

endmodule